// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block sends characters on a single serial output line. Bytes are written into a 128-entry queue. A frame sequencer takes them out one at a time and shifts each one out as an asynchronous character. All bit timing comes from a clock-enable pulse that runs at sixteen times the bit rate. That pulse is made outside the block, either by a divider or from an external clock input.

The character format is set at run time by four configuration inputs: data width (7 or 8 bits), parity on or off, parity sense, and one or two stop bits. These inputs are sampled when a character starts, so they must be held stable while characters that use them are still queued. The receiving side holds back new characters by driving the active-low clear-to-send input high. A character that has already started always finishes. The queue fill level is always visible, and a write into a full queue is dropped and recorded.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset `txd` is 1, `fill_count` is 0, `full` is 0 and `overflow` is 0.
- R2: A character is sent as a 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits at 1. Each bit lasts 16 `tick16` pulses, and the line is 1 whenever no character is being sent.
- R3: With `cfg_len8`=1 all eight data bits are sent. With `cfg_len8`=0 only bits 6..0 are sent and bit 7 of the written byte has no effect on the line.
- R4: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_odd`=0 the data bits plus the parity bit hold an even number of ones, and with `cfg_par_odd`=1 an odd number. With `cfg_par_en`=0 no parity bit is sent.
- R5: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R6: The queue holds up to 128 bytes and sends them in write order. `fill_count` gives the number held, and when the line is busy and the queue is not empty the next character starts on the `tick16` pulse that ends the previous one.
- R7: A write while `full` is 1 is dropped, leaving `fill_count` and the sent data unchanged, and sets `overflow`, which stays 1 until reset.
- R8: A character starts only on a `tick16` pulse at which `cts_n` is 0. Raising `cts_n` during a character lets that character finish and holds back the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16x bit rate |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to write |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output line |
| fill_count | output | 8 | Bytes held in the queue (0..128) |
| full | output | 1 | Queue holds 128 bytes |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
A write shows up in `fill_count` one clock after it is presented. The start bit appears on `txd` in the clock that follows the starting `tick16` pulse, and `fill_count` drops at that same edge. The monitor samples `txd` on the falling clock edge of each `tick16` cycle, so the value it reads is the one registered at that pulse. Counting from the pulse where it saw the start bit, it reads bit k at pulse 16k+8. It then compares the whole frame with the byte and format the driver queued. The flow-control and full-queue checks read `txd` and `fill_count` only after enough pulses for a held-back character to have started if the block were wrong.

// File: rtl/serial_tx_queue.sv
module serial_tx_queue #(
  parameter int DEPTH = 128,
  parameter int OVS   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       cfg_len8,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       cfg_stop2,
  input  logic                       cts_n,
  output logic                       txd,
  output logic [$clog2(DEPTH):0]     fill_count,
  output logic                       full,
  output logic                       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int PW = $clog2(OVS);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          active;
  logic [PW-1:0] phase;
  logic [3:0]    bitn, nbits;
  logic [11:0]   sh;
  logic          txq;
  logic [11:0]   frm;
  logic [7:0]    cur, dat;
  logic [3:0]    nb_next;

  assign full       = (cnt == CW'(DEPTH));
  assign fill_count = cnt;
  assign txd        = txq;

  wire empty  = (cnt == '0);
  wire push   = wr_en && !full;
  wire last   = active && tick16 && (phase == PW'(OVS-1)) && (bitn == nbits - 4'd1);
  wire launch = tick16 && !cts_n && !empty && (!active || last);

  assign cur     = mem[rptr];
  assign dat     = cfg_len8 ? cur : {1'b0, cur[6:0]};
  assign nb_next = 4'd9 + {3'b0, cfg_len8} + {3'b0, cfg_par_en} + {3'b0, cfg_stop2};

  always_comb begin
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || cfg_len8) frm[i+1] = cur[i];
    if (cfg_par_en) frm[cfg_len8 ? 9 : 8] = ^dat ^ cfg_par_odd;
  end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (push)   wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (launch) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(launch);
      if (wr_en && full) overflow <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
      bitn   <= '0;
      nbits  <= '0;
      sh     <= '1;
      txq    <= 1'b1;
    end else if (launch) begin
      active <= 1'b1;
      phase  <= '0;
      bitn   <= '0;
      nbits  <= nb_next;
      sh     <= frm;
      txq    <= frm[0];
    end else if (active && tick16) begin
      if (phase == PW'(OVS-1)) begin
        phase <= '0;
        if (last) begin
          active <= 1'b0;
          txq    <= 1'b1;
        end else begin
          bitn <= bitn + 4'd1;
          sh   <= {1'b1, sh[11:1]};
          txq  <= sh[1];
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
endmodule

// File: rtl/serial_tx_queue_chk.sv
module serial_tx_queue_chk #(
  parameter int DEPTH = 128
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   full,
  input logic                   txd,
  input logic                   cts_n,
  input logic                   active,
  input logic                   launch,
  input logic [$clog2(DEPTH):0] fill_count,
  input logic                   overflow
);
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !launch) |=> $stable(fill_count));

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= ($clog2(DEPTH)+1)'(DEPTH));

  // R8
  cts_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(!cts_n));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !txd);
endmodule

bind serial_tx_queue serial_tx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .full(full), .txd(txd),
  .cts_n(cts_n), .active(active), .launch(launch),
  .fill_count(fill_count), .overflow(overflow)
);

// File: tb/serial_tx_queue_bench.sv
module serial_tx_queue_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic cts_n = 1'b1;
  logic txd, full, overflow;
  logic [7:0] fill_count;

  int checks = 0, fails = 0;
  logic [11:0] expq [$];
  bit mon_busy = 0;
  int cyc = 0;

  serial_tx_queue u_serial_tx_queue (.*);

  always #2 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv + 1) % 2;
    tick16 <= (tdiv == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input bit expect_sent);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    if (expect_sent) expq.push_back({cfg_stop2, cfg_par_odd, cfg_par_en, cfg_len8, d});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic void build(input logic [11:0] it, output logic [11:0] b, output int n);
    int ones = 0;
    int w = it[8] ? 8 : 7;
    b = '1; b[0] = 1'b0; n = 1;
    for (int i = 0; i < w; i++) begin
      b[n] = it[i]; ones += it[i]; n++;
    end
    if (it[9]) begin
      b[n] = it[10] ? ~ones[0] : ones[0]; n++;
    end
    n += it[11] ? 2 : 1;
  endfunction

  logic [11:0] mbits, mitem;
  int mn, tcnt, mbad, frames = 0;
  always @(negedge clk) begin
    if (rst_n && tick16) begin
      if (!mon_busy) begin
        if (txd == 1'b0) begin
          if (expq.size() == 0) chk(0, "R7 unexpected frame", 1, 0);
          else begin
            mitem = expq.pop_front();
            build(mitem, mbits, mn);
            tcnt = 0; mbad = 0; mon_busy = 1;
          end
        end
      end else begin
        tcnt++;
        if (tcnt % 16 == 8 && txd !== mbits[tcnt/16]) mbad++;
        if (tcnt == 16*mn - 1) begin
          mon_busy = 0; frames++;
          // R2 R3 R4 R5 R6: whole frame compared against the queued item
          chk(mbad == 0, "R2/R3/R4/R5 frame bits", mbad, 0);
        end
      end
    end
  end

  task automatic drain();
    wait (expq.size() == 0 && !mon_busy && fill_count == 0);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int low;
    repeat (5) @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1 txd at reset", txd, 1);
    chk(fill_count == 0, "R1 fill at reset", fill_count, 0);
    chk(overflow == 0 && full == 0, "R1 flags at reset", overflow, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 fill count with flow blocked
    wr(8'hA5, 1); wr(8'h3C, 1); wr(8'h81, 1);
    chk(fill_count == 3, "R6 fill after 3 writes", fill_count, 3);
    // R8 blocked: line stays idle
    low = 0;
    repeat (400) begin @(negedge clk); if (txd == 0) low++; end
    chk(low == 0, "R8 no start while cts_n high", low, 0);
    chk(fill_count == 3, "R8 queue held", fill_count, 3);

    // 8N1 drain, back to back (R6)
    cts_n = 1'b0;
    drain();
    chk(frames == 3, "R6 frames sent", frames, 3);

    // R3 R4 7-bit even parity, bit 7 ignored
    cfg_len8 = 0; cfg_par_en = 1; cfg_par_odd = 0;
    wr(8'hFF, 1); wr(8'h80, 1); wr(8'h13, 1);
    drain();
    // R4 R5 8-bit odd parity, 2 stop
    cfg_len8 = 1; cfg_par_odd = 1; cfg_stop2 = 1;
    wr(8'h00, 1); wr(8'hF7, 1);
    drain();
    // R5 7N2
    cfg_len8 = 0; cfg_par_en = 0;
    wr(8'h55, 1); wr(8'h2A, 1);
    drain();
    cfg_len8 = 1; cfg_stop2 = 0;

    // R8 in-flight character completes, next held
    wr(8'hC3, 1); wr(8'h5A, 1);
    repeat (60) @(negedge clk);
    cts_n = 1'b1;
    wait (!mon_busy);
    repeat (500) @(negedge clk);
    chk(fill_count == 1, "R8 next char held", fill_count, 1);
    chk(expq.size() == 1, "R8 one frame done", expq.size(), 1);
    cts_n = 1'b0;
    drain();

    // R7 overflow
    cts_n = 1'b1;
    for (int i = 0; i < 128; i++) wr(8'(i * 7 + 1), 1);
    chk(full == 1, "R7 full flag", full, 1);
    chk(overflow == 0, "R7 no overflow yet", overflow, 0);
    wr(8'hEE, 0);
    chk(fill_count == 128, "R7 fill stays 128", fill_count, 128);
    chk(overflow == 1, "R7 overflow set", overflow, 1);
    cts_n = 1'b0;
    drain();
    chk(overflow == 1, "R7 overflow sticky", overflow, 1);
    chk(fill_count == 0 && txd == 1, "R7 drained", fill_count, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    chk(0, "watchdog", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule